// File: doc/BRIEF.md
# Edge-Counting Subcarrier Bit Receiver

This block recovers a short response frame from one digital input line. During a logic-1 bit the line carries a subcarrier, so it toggles many times. During a logic-0 bit it stays quiet. The response has no start marker, no stop marker and no length field. The controller therefore supplies the bit count and pulses a start strobe in the clock cycle where its own outgoing frame ends.

After that strobe the block waits a fixed turnaround time. It then cuts time into back-to-back windows of equal length, one window per bit. The input passes through a two-flop synchroniser, and every change of level is counted, rising and falling alike. When a window closes, its count is compared against an open range. A count inside the range gives a 1, and any other count gives a 0.

The decoded bits are packed least-significant first and XORed with a keystream word that is captured at the start. The finished word is presented together with a one-cycle valid pulse.

Top module: `edge_bit_rx`

## Requirements
- R1: The first bit window starts GUARD_CYC clock cycles after the cycle in which start_i is sampled high. Level changes during this turnaround are not counted in any window.
- R2: Each bit has one window of WIN_CYC clock cycles. Window k covers the k-th run of WIN_CYC cycles after the turnaround, and consecutive windows do not overlap.
- R3: Rising and falling changes of the synchronised input both count. A window decodes as 1 only when its count is strictly greater than EDGE_LO (default 20) and strictly less than EDGE_HI (default 60). With the defaults, counts of 20 and 60 give 0, and counts of 21, 42 and 59 give 1.
- R4: The per-window counter saturates at its all-ones value, which is 63 for the default EDGE_HI. A window holding more changes than that, for example 75, decodes as 0 and never wraps back into the 1 range.
- R5: Bit k of data_o is the decision for window k XORed with bit k of key_i, where key_i is captured in the start cycle. Bit 0 is the first window.
- R6: The bit count nbits_i is clamped. A request of 0 gives 1 bit, and a request above MAX_BITS (32) gives MAX_BITS bits. Bits of data_o at positions equal to or above the clamped count are 0.
- R7: valid_o is high for exactly one cycle, GUARD_CYC + N*WIN_CYC cycles after the start sample, where N is the clamped count. data_o keeps that word until the next frame completes.
- R8: start_i is ignored while a frame is being received. The count, the key and the timing of the frame in progress are unchanged.
- R9: After reset valid_o is 0, data_o is 0 and the block waits for start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Strobe at the end of the outgoing frame; begins reception |
| nbits_i | input | NB_W (6) | Requested bit count, clamped to 1..MAX_BITS |
| key_i | input | MAX_BITS (32) | Keystream word, captured with start_i |
| rx_i | input | 1 | Asynchronous subcarrier line |
| data_o | output | MAX_BITS (32) | Decoded word, LSB is the first bit |
| valid_o | output | 1 | One-cycle pulse when data_o is updated |

## Verification
Windows are driven with exact change counts on both sides of each threshold (20/21 and 59/60), with a typical 42, with zero, and with 75 and 85. The 75 and 85 cases separate a saturating counter from a wrapping one. Toggling during the turnaround, with a silent first window, shows whether the guard time is really discarded. A second start pulse in the middle of a frame, carrying a different count and key, shows whether the block ignores start_i while busy.

Requested lengths of 0, 40 and random values in 1..32, each with random keys, exercise the clamp, the masking of unused bits and the latency formula. Random mixes of counts exercise bit ordering and the keystream XOR.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GUARD = 2'd1,
        ST_WIN   = 2'd2
    } rx_state_e;

endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic edge_o
);
    // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], rx_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];

endmodule

// File: rtl/rx_sat_counter.sv
module rx_sat_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] sum_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        // total including the change seen in this cycle
        sum_o = (inc_i && (cnt_q != TOP)) ? cnt_q + 1'b1 : cnt_q;
        cnt_d = clr_i ? '0 : sum_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/rx_bit_judge.sv
module rx_bit_judge #(
    parameter int CNT_W   = 6,
    parameter int EDGE_LO = 20,
    parameter int EDGE_HI = 60
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic             bit_o
);
    localparam logic [CNT_W-1:0] LO_V = CNT_W'(EDGE_LO);
    localparam logic [CNT_W-1:0] HI_V = CNT_W'(EDGE_HI);

    assign bit_o = (cnt_i > LO_V) && (cnt_i < HI_V);

endmodule

// File: rtl/edge_bit_rx.sv
module edge_bit_rx
    import rx_pkg::*;
#(
    parameter int GUARD_CYC   = 82500,
    parameter int WIN_CYC     = 25000,
    parameter int EDGE_LO     = 20,
    parameter int EDGE_HI     = 60,
    parameter int MAX_BITS    = 32,
    parameter int SYNC_STAGES = 2,
    parameter int NB_W        = $clog2(MAX_BITS) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [NB_W-1:0]     nbits_i,
    input  logic [MAX_BITS-1:0] key_i,
    input  logic                rx_i,
    output logic [MAX_BITS-1:0] data_o,
    output logic                valid_o
);
    localparam int SPAN  = (GUARD_CYC > WIN_CYC) ? GUARD_CYC : WIN_CYC;
    localparam int TMR_W = $clog2(SPAN + 1);
    localparam int CNT_W = $clog2(EDGE_HI + 1);

    localparam logic [TMR_W-1:0] GUARD_LAST = TMR_W'(GUARD_CYC - 1);
    localparam logic [TMR_W-1:0] WIN_LAST   = TMR_W'(WIN_CYC - 1);
    localparam logic [NB_W-1:0]  MAX_N      = NB_W'(MAX_BITS);

    typedef struct packed {
        rx_state_e           st;
        logic [TMR_W-1:0]    tmr;
        logic [NB_W-1:0]     idx;
        logic [NB_W-1:0]     len;
        logic [MAX_BITS-1:0] key;
        logic [MAX_BITS-1:0] acc;
        logic [MAX_BITS-1:0] data;
        logic                valid;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic             edge_pulse;
    logic             win_clr;
    logic [CNT_W-1:0] win_sum;
    logic [CNT_W-1:0] win_cnt_q;
    logic             win_bit;
    logic             busy;
    logic             win_end;

    function automatic logic [NB_W-1:0] clamp_len(input logic [NB_W-1:0] n);
        if (n == '0)        return NB_W'(1);
        else if (n > MAX_N) return MAX_N;
        else                return n;
    endfunction

    function automatic logic [MAX_BITS-1:0] low_mask(input logic [NB_W-1:0] n);
        logic [MAX_BITS-1:0] m;
        for (int i = 0; i < MAX_BITS; i++) m[i] = (NB_W'(i) < n);
        return m;
    endfunction

    rx_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .edge_o (edge_pulse)
    );

    rx_sat_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (win_clr),
        .inc_i (edge_pulse),
        .sum_o (win_sum),
        .cnt_o (win_cnt_q)
    );

    rx_bit_judge #(
        .CNT_W   (CNT_W),
        .EDGE_LO (EDGE_LO),
        .EDGE_HI (EDGE_HI)
    ) u_judge (
        .cnt_i (win_sum),
        .bit_o (win_bit)
    );

    assign busy    = (r_q.st != ST_IDLE);
    assign win_end = (r_q.st == ST_WIN) && (r_q.tmr == WIN_LAST);
    // counter only accumulates inside a window; restarts at each boundary
    assign win_clr = (r_q.st != ST_WIN) || win_end;

    always_comb begin
        logic [NB_W-1:0]     n_cl;
        logic [MAX_BITS-1:0] acc_n;
        r_d       = r_q;
        r_d.valid = 1'b0;
        n_cl      = clamp_len(nbits_i);
        acc_n     = r_q.acc;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st  = ST_GUARD;
                    r_d.tmr = '0;
                    r_d.idx = '0;
                    r_d.len = n_cl;
                    r_d.key = key_i & low_mask(n_cl);
                    r_d.acc = '0;
                end
            end
            ST_GUARD: begin
                if (r_q.tmr == GUARD_LAST) begin
                    r_d.st  = ST_WIN;
                    r_d.tmr = '0;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            ST_WIN: begin
                if (win_end) begin
                    for (int i = 0; i < MAX_BITS; i++) begin
                        if (r_q.idx == NB_W'(i)) acc_n[i] = win_bit;
                    end
                    r_d.acc = acc_n;
                    r_d.tmr = '0;
                    r_d.idx = r_q.idx + 1'b1;
                    if (r_q.idx + 1'b1 == r_q.len) begin
                        r_d.st    = ST_IDLE;
                        r_d.valid = 1'b1;
                        r_d.data  = acc_n ^ r_q.key;
                    end
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_o  = r_q.data;
    assign valid_o = r_q.valid;

endmodule

// File: rtl/edge_bit_rx_chk.sv
module edge_bit_rx_chk #(
    parameter int GUARD_CYC = 82500,
    parameter int WIN_CYC   = 25000,
    parameter int MAX_BITS  = 32,
    parameter int NB_W      = 6,
    parameter int CNT_W     = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [NB_W-1:0]     nbits_i,
    input logic [MAX_BITS-1:0] data_o,
    input logic                valid_o,
    input logic                busy_i,
    input logic [CNT_W-1:0]    cnt_i
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [NB_W-1:0] len_q;
    logic [31:0]     cyc_q;
    logic            trk_q;
    logic [31:0]     lat_exp;
    logic [MAX_BITS-1:0] hi_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            cyc_q <= '0;
            trk_q <= 1'b0;
        end else if (start_i && !busy_i) begin
            if (nbits_i == '0)                   len_q <= NB_W'(1);
            else if (nbits_i > NB_W'(MAX_BITS)) len_q <= NB_W'(MAX_BITS);
            else                                 len_q <= nbits_i;
            cyc_q <= '0;
            trk_q <= 1'b1;
        end else begin
            if (trk_q)   cyc_q <= cyc_q + 1;
            if (valid_o) trk_q <= 1'b0;
        end
    end

    always_comb begin
        lat_exp = 32'(GUARD_CYC) + 32'(len_q) * 32'(WIN_CYC);
        for (int i = 0; i < MAX_BITS; i++) hi_mask[i] = (NB_W'(i) >= len_q);
    end

    // R7: one-cycle pulse
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7, R1, R2: latency from start sample to valid
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (trk_q && cyc_q == lat_exp));

    // R6: unused upper bits are zero
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((data_o & hi_mask) == '0));

    // R8: reception only begins on a start pulse
    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_i) |-> $past(start_i));

    // R4: a full counter stays full until cleared
    a_r4_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_i) == TOP && cnt_i != '0) |-> cnt_i == TOP);

    // R3: counter advances by at most one per cycle
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (cnt_i == '0 || cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + 1'b1));

endmodule

bind edge_bit_rx edge_bit_rx_chk #(
    .GUARD_CYC (GUARD_CYC),
    .WIN_CYC   (WIN_CYC),
    .MAX_BITS  (MAX_BITS),
    .NB_W      (NB_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .nbits_i (nbits_i),
    .data_o  (data_o),
    .valid_o (valid_o),
    .busy_i  (busy),
    .cnt_i   (win_cnt_q)
);

// File: tb/tb_edge_bit_rx.sv
module tb_edge_bit_rx;
    localparam int G  = 40;
    localparam int W  = 100;
    localparam int MB = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  nbits_i = '0;
    logic [31:0] key_i = '0;
    logic        rx_i = 1'b0;
    logic [31:0] data_o;
    logic        valid_o;

    int n_chk = 0;
    int n_bad = 0;
    int ed [32];

    always #2 clk = ~clk;

    edge_bit_rx #(
        .GUARD_CYC (G),
        .WIN_CYC   (W),
        .EDGE_LO   (20),
        .EDGE_HI   (60),
        .MAX_BITS  (MB)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .nbits_i (nbits_i),
        .key_i   (key_i),
        .rx_i    (rx_i),
        .data_o  (data_o),
        .valid_o (valid_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic int clamp_n(input int n);
        if (n == 0) return 1;
        if (n > MB) return MB;
        return n;
    endfunction

    function automatic logic [31:0] model(input int nreq, input logic [31:0] key);
        logic [31:0] r = '0;
        int n = clamp_n(nreq);
        for (int i = 0; i < n; i++) begin
            r[i] = ((ed[i] > 20) && (ed[i] < 60)) ^ key[i];
        end
        return r;
    endfunction

    task automatic run_frame(input int nreq, input logic [31:0] key,
                             input int noise, input bit poke, input string tag);
        int nc = clamp_n(nreq);
        int lat = -1;
        logic [31:0] got = '0;
        logic [31:0] exp = model(nreq, key);
        @(negedge clk);
        start_i = 1'b1;
        nbits_i = 6'(nreq);
        key_i   = key;
        @(posedge clk);
        for (int k = 0; k < G + 33 * W + 10; k++) begin
            @(negedge clk);
            start_i = poke && (k == G + 150);
            if (poke && k == G + 150) begin
                nbits_i = 6'd3;
                key_i   = 32'hFFFF_FFFF;
            end
            if (valid_o) begin
                lat = k;
                got = data_o;
                break;
            end
            if (k >= 5 && k < 5 + noise) rx_i = ~rx_i;
            if (k >= G) begin
                int w = (k - G) / W;
                int o = (k - G) % W;
                if (w < nc && o >= 10 && o < 10 + ed[w]) rx_i = ~rx_i;
            end
        end
        chk(got == exp, {"R5/R3 data ", tag}, got, exp);
        chk(lat == G + nc * W, {"R7/R1/R2 latency ", tag}, 32'(lat), 32'(G + nc * W));
        @(negedge clk);
        chk(!valid_o, {"R7 pulse width ", tag}, 32'(valid_o), 0);
        chk(data_o == exp, {"R7 data held ", tag}, data_o, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(valid_o == 1'b0, "R9 reset valid", 32'(valid_o), 0);
        chk(data_o == '0, "R9 reset data", data_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 thresholds, R4 saturation (75, 85 changes)
        ed[0] = 20; ed[1] = 21; ed[2] = 59; ed[3] = 60;
        ed[4] = 0;  ed[5] = 42; ed[6] = 75; ed[7] = 85;
        run_frame(8, 32'h0, 0, 0, "thresholds");
        chk(data_o == 32'h26, "R4 saturating count decodes 0", data_o, 32'h26);

        // R1: changes during turnaround must not reach window 0
        ed[0] = 0; ed[1] = 42; ed[2] = 0; ed[3] = 42;
        run_frame(4, 32'h0, 25, 0, "guard noise R1");

        // R6: zero request gives one bit
        ed[0] = 42;
        run_frame(0, 32'hFFFF_FFFF, 0, 0, "len0 R6");

        // R6: oversize request clamps to 32
        for (int i = 0; i < 32; i++) ed[i] = (i % 3 == 0) ? 42 : 5;
        run_frame(40, 32'hA5A5_0F0F, 0, 0, "len40 R6");

        // all ones, full width, R5
        for (int i = 0; i < 32; i++) ed[i] = 42;
        run_frame(32, 32'h0, 0, 0, "all ones R5");

        // R8: start pulse mid-frame with different length and key
        ed[0] = 42; ed[1] = 0; ed[2] = 42; ed[3] = 42; ed[4] = 0; ed[5] = 30;
        run_frame(6, 32'h0000_0013, 0, 1, "busy start R8");

        // random frames
        for (int f = 0; f < 12; f++) begin
            int nreq = 1 + int'($urandom_range(31, 0));
            logic [31:0] key = $urandom();
            if (f == 3) nreq = 0;
            if (f == 7) nreq = 50;
            for (int i = 0; i < 32; i++) begin
                case ($urandom_range(5, 0))
                    0: ed[i] = 0;
                    1: ed[i] = 42;
                    2: ed[i] = 20 + int'($urandom_range(1, 0));
                    3: ed[i] = 59 + int'($urandom_range(1, 0));
                    default: ed[i] = int'($urandom_range(85, 0));
                endcase
            end
            run_frame(nreq, key, int'($urandom_range(25, 0)), (f % 4 == 1), "random R5");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule